// File: doc/BRIEF.md
# Burst-Mode Synchronous SRAM Core

This block is a single-data-rate synchronous memory whose burst length is chosen on the fly. Each rising clock edge samples an address and three burst-control pins. A start cycle opens a read or write burst at the sampled address. A continue cycle extends that burst to the next address inside an aligned group of four words. A no-operation cycle closes the burst. The caller picks a burst of one, two or four transfers by issuing zero, one or three continues after the start. Continues beyond the third are reported as invalid, and the in-burst address keeps wrapping.

Read data appears one clock after the beat's address is sampled and is driven only while the output enable is high. An echo clock follows the input clock while read data is valid. The data bus is split into input, output and output-enable ports, so the parent level decides how to build a pad. The pins are plain synchronous pins with fixed timing. There is no valid/ready handshake, and the caller cannot apply back-pressure: a read beat is presented for exactly one cycle and has to be taken in that cycle.

Top module: `sbs_burst_sram`

## Requirements
- R1: Starting a read (`bc_lead_n`=0, `bc_kind`=1) at address A puts the stored word of A on `dq_out` in the cycle after the sampling edge.
- R2: Starting a write (`bc_lead_n`=0, `bc_kind`=0) stores `dq_in` at the start address on the sampling edge, and each accepted continue stores `dq_in` at the next burst address on its own edge.
- R3: In a burst, bits [1:0] of the beat address count up by one modulo 4 from the start address, and the upper address bits stay those of the start address.
- R4: A burst has 1, 2 or 4 transfers, depending on how many continues (`bc_lead_n`=1, `bc_kind`=1) follow the start (0, 1 or 3). A no-operation (`bc_lead_n`=1, `bc_kind`=0) ends the burst.
- R5: `bad_cont` is high for exactly the cycle after a continue that is either the fourth or later continue of a burst, or has no open burst. A late continue still performs a wrapped beat. A continue with no open burst performs no access.
- R6: `dq_oe` is low in the cycle after a no-operation, a write start or an orphan continue, and is low whenever no read beat is pending.
- R7: `dq_oe` is high only when a read beat is pending and `out_en` is high. `out_en` acts combinationally.
- R8: `echo_clk` equals `clk` while a read beat is pending, and is low otherwise.
- R9: During reset, `dq_oe`, `bad_cont` and `echo_clk` are low.
- R10: `bc_spare` has no effect on any output or on stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low reset |
| addr | input | AW | Word address, used on start cycles |
| bc_lead_n | input | 1 | Low to start a new operation |
| bc_kind | input | 1 | With `bc_lead_n` low: 1 read, 0 write. With it high: 1 continue, 0 no-operation |
| bc_spare | input | 1 | Third burst-control pin, not used |
| out_en | input | 1 | Output enable for the read data bus |
| dq_in | input | DW | Write data |
| dq_out | output | DW | Read data |
| dq_oe | output | 1 | High while `dq_out` should be driven |
| echo_clk | output | 1 | Echo of `clk` while read data is valid |
| bad_cont | output | 1 | One-cycle flag for an invalid continue |

## Verification
The bound checker checks on every cycle how the control pins relate to the outputs. It checks the `bad_cont` flag against its own count of continues, that the drive is dropped after a no-operation or a write start, that `out_en` gates `dq_oe`, that a read start gives drive, and that the echo clock follows `clk`. Only the bench scenarios can show the data values: that written words come back from the right addresses, that the low address bits wrap inside a burst, that over-long bursts return the wrapped words, and that toggling the spare pin changes nothing.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
  typedef enum logic [1:0] {
    CMD_NOP  = 2'd0,
    CMD_RD   = 2'd1,
    CMD_WR   = 2'd2,
    CMD_CONT = 2'd3
  } cmd_e;

  function automatic cmd_e decode_cmd(input logic lead_n, input logic kind);
    if (!lead_n) return kind ? CMD_RD : CMD_WR;
    return kind ? CMD_CONT : CMD_NOP;
  endfunction
endpackage

// File: rtl/sbs_cmd_decode.sv
`timescale 1ns/1ps
module sbs_cmd_decode
  import sbs_pkg::*;
(
  input  logic lead_n,
  input  logic kind,
  output cmd_e cmd
);
  always_comb cmd = decode_cmd(lead_n, kind);
endmodule

// File: rtl/sbs_burst_ctr.sv
`timescale 1ns/1ps
module sbs_burst_ctr
  import sbs_pkg::*;
#(
  parameter int AW        = 6,
  parameter int BEAT_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cmd_e          cmd,
  input  logic [AW-1:0] addr,
  output logic          beat_go,
  output logic          beat_rd,
  output logic [AW-1:0] beat_addr,
  output logic          bad_cont
);
  localparam int HW       = AW - BEAT_BITS;
  localparam int MAX_CONT = (1 << BEAT_BITS) - 1;
  localparam int CW       = $clog2(MAX_CONT + 1);

  logic                 open_q;
  logic                 is_rd_q;
  logic [HW-1:0]        hi_q;
  logic [BEAT_BITS-1:0] off_q;
  logic [BEAT_BITS-1:0] off_nx;
  logic [CW-1:0]        cnt_q;
  logic                 over;

  assign off_nx = off_q + 1'b1;
  assign over   = open_q && (cnt_q == CW'(MAX_CONT));

  always_comb begin
    beat_go   = 1'b0;
    beat_rd   = is_rd_q;
    beat_addr = {hi_q, off_nx};
    unique case (cmd)
      CMD_RD, CMD_WR: begin
        beat_go   = 1'b1;
        beat_rd   = (cmd == CMD_RD);
        beat_addr = addr;
      end
      CMD_CONT: beat_go = open_q;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      hi_q     <= '0;
      off_q    <= '0;
      cnt_q    <= '0;
      bad_cont <= 1'b0;
    end else begin
      bad_cont <= (cmd == CMD_CONT) && (!open_q || over);
      unique case (cmd)
        CMD_RD, CMD_WR: begin
          open_q  <= 1'b1;
          is_rd_q <= (cmd == CMD_RD);
          hi_q    <= addr[AW-1:BEAT_BITS];
          off_q   <= addr[BEAT_BITS-1:0];
          cnt_q   <= '0;
        end
        CMD_CONT: begin
          if (open_q) begin
            off_q <= off_nx;
            if (!over) cnt_q <= cnt_q + 1'b1;
          end
        end
        default: open_q <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= din;
    if (rd) dout <= mem[addr];
  end
endmodule

// File: rtl/sbs_rdpath.sv
`timescale 1ns/1ps
module sbs_rdpath (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_beat,
  input  logic out_en,
  output logic rd_valid,
  output logic dq_oe,
  output logic echo_clk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_beat;
  end
  assign dq_oe    = rd_valid & out_en;
  assign echo_clk = clk & rd_valid;
endmodule

// File: rtl/sbs_burst_sram.sv
`timescale 1ns/1ps
module sbs_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW        = 6,
  parameter int DW        = 16,
  parameter int BEAT_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          bc_lead_n,
  input  logic          bc_kind,
  input  logic          bc_spare,
  input  logic          out_en,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          echo_clk,
  output logic          bad_cont
);
  cmd_e          cmd;
  logic          beat_go, beat_rd, rd_valid;
  logic [AW-1:0] beat_addr;
  logic          unused_spare;

  assign unused_spare = bc_spare;

  sbs_cmd_decode u_dec (
    .lead_n(bc_lead_n), .kind(bc_kind), .cmd(cmd)
  );

  sbs_burst_ctr #(.AW(AW), .BEAT_BITS(BEAT_BITS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .addr(addr),
    .beat_go(beat_go), .beat_rd(beat_rd), .beat_addr(beat_addr),
    .bad_cont(bad_cont)
  );

  sbs_array #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .wr(beat_go && !beat_rd), .rd(beat_go && beat_rd),
    .addr(beat_addr), .din(dq_in), .dout(dq_out)
  );

  sbs_rdpath u_rd (
    .clk(clk), .rst_n(rst_n), .rd_beat(beat_go && beat_rd), .out_en(out_en),
    .rd_valid(rd_valid), .dq_oe(dq_oe), .echo_clk(echo_clk)
  );
endmodule

// File: rtl/sbs_burst_sram_chk.sv
`timescale 1ns/1ps
module sbs_burst_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic bc_lead_n,
  input logic bc_kind,
  input logic out_en,
  input logic dq_oe,
  input logic echo_clk,
  input logic bad_cont
);
  logic       open_c;
  logic [1:0] cnt_c;
  logic       is_start, is_nop, is_cont, is_rd_start, is_wr_start, invalid;

  assign is_start    = !bc_lead_n;
  assign is_rd_start = !bc_lead_n && bc_kind;
  assign is_wr_start = !bc_lead_n && !bc_kind;
  assign is_nop      = bc_lead_n && !bc_kind;
  assign is_cont     = bc_lead_n && bc_kind;
  assign invalid     = is_cont && (!open_c || cnt_c == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_c <= 1'b0;
      cnt_c  <= 2'd0;
    end else if (is_start) begin
      open_c <= 1'b1;
      cnt_c  <= 2'd0;
    end else if (is_nop) begin
      open_c <= 1'b0;
    end else if (open_c && cnt_c != 2'd3) begin
      cnt_c <= cnt_c + 2'd1;
    end
  end

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |=> bad_cont);
  a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !invalid |=> !bad_cont);
  a_r6_nop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |=> !dq_oe);
  a_r6_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr_start |=> !dq_oe);
  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !dq_oe);
  a_r1_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd_start |=> (dq_oe == out_en));
  a_r8_echo_low: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_clk);
  a_r8_echo_high: assert property (@(negedge clk) disable iff (!rst_n)
    out_en |-> (echo_clk == dq_oe));
endmodule

bind sbs_burst_sram sbs_burst_sram_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bc_lead_n(bc_lead_n), .bc_kind(bc_kind),
  .out_en(out_en), .dq_oe(dq_oe), .echo_clk(echo_clk), .bad_cont(bad_cont)
);

// File: tb/test_sbs_burst_sram.sv
`timescale 1ns/1ps
module test_sbs_burst_sram;
  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          bc_lead_n, bc_kind, bc_spare, out_en;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe, echo_clk, bad_cont;

  always #4 clk = ~clk;

  sbs_burst_sram #(.AW(AW), .DW(DW)) i_sbs_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bc_lead_n(bc_lead_n),
    .bc_kind(bc_kind), .bc_spare(bc_spare), .out_en(out_en), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .echo_clk(echo_clk), .bad_cont(bad_cont)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit pend = 0;
  string scen = "";
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  // reference model state
  logic [DW-1:0] ref_mem [1 << AW];
  bit            m_open = 0;
  bit            m_rd = 0;
  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_off = '0;
  int            m_cnt = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h", tag, what, scen, act, exp);
    end
  endtask

  // scoreboard monitor: one expected read word per cycle, popped mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_q.size() > 0) begin
        logic [DW-1:0] d;
        string t;
        d = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dq_oe === 1'b1, t, "drive", 32'(dq_oe), 1);
        check(dq_out === d, t, "data", 32'(dq_out), 32'(d));
      end else begin
        check(dq_oe === 1'b0, out_en ? "R4 R6" : "R7", "idle drive", 32'(dq_oe), 0);
      end
      check(echo_clk === 1'b0, "R8", "echo low phase", 32'(echo_clk), 0);
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done)
      check(echo_clk === pend, "R8", "echo high phase", 32'(echo_clk), 32'(pend));
  end

  // driver: one command per cycle, model update, expected push at the edge
  task automatic cyc(input bit lead_n, input bit kind, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    bit go = 0;
    bit err = 0;
    bit first = 0;
    logic [AW-1:0] ba = '0;
    bc_lead_n = lead_n;
    bc_kind   = kind;
    bc_spare  = ~bc_spare;  // R10: toggles on every cycle
    addr      = a;
    dq_in     = d;
    if (!lead_n) begin
      m_open = 1; m_rd = kind; m_hi = a[AW-1:2]; m_off = a[1:0]; m_cnt = 0;
      go = 1; first = 1; ba = a;
    end else if (kind) begin
      if (!m_open) err = 1;
      else begin
        err = (m_cnt == 3);
        if (m_cnt < 3) m_cnt++;
        m_off = m_off + 2'd1;
        go = 1;
        ba = {m_hi, m_off};
      end
    end else begin
      m_open = 0;
    end
    @(posedge clk);
    pend = go && m_rd;
    if (go && m_rd && out_en) begin
      exp_q.push_back(ref_mem[ba]);
      tag_q.push_back(first ? "R1 R2" : (err ? "R5 R3" : "R2 R3"));
    end
    if (go && !m_rd) ref_mem[ba] = d;
    #1;
    check(bad_cont === err, "R5", "invalid-continue flag", 32'(bad_cont), 32'(err));
  endtask

  task automatic nop();
    cyc(1, 0, '0, '0);
  endtask
  task automatic cont(input logic [DW-1:0] d);
    cyc(1, 1, '0, d);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bc_lead_n = 1; bc_kind = 0; bc_spare = 0; out_en = 1;
    addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    scen = "reset";
    check(dq_oe === 1'b0, "R9", "oe in reset", 32'(dq_oe), 0);
    check(bad_cont === 1'b0, "R9", "flag in reset", 32'(bad_cont), 0);
    check(echo_clk === 1'b0, "R9", "echo in reset", 32'(echo_clk), 0);
    @(posedge clk); #1 rst_n = 1;

    scen = "write burst of 4";
    cyc(0, 0, 6'd8, 16'hA000); cont(16'hB001); cont(16'hC002); cont(16'hD003);
    nop();

    scen = "read burst of 4";
    cyc(0, 1, 6'd8, '0); cont('0); cont('0); cont('0);
    nop();

    scen = "write wrapping from 13";
    cyc(0, 0, 6'd13, 16'h0101); cont(16'h0202); cont(16'h0303); cont(16'h0404);
    nop();

    scen = "read lengths 2 and 1, wrap";
    cyc(0, 1, 6'd15, '0); cont('0);   // 15 then 12
    cyc(0, 1, 6'd13, '0);             // single beat, back to back
    nop();

    scen = "over-long continue";
    cyc(0, 1, 6'd8, '0);
    for (int i = 0; i < 5; i++) cont('0);
    nop();

    scen = "orphan continue";
    cont(16'hFFFF); cont(16'hEEEE);
    nop();
    cyc(0, 1, 6'd8, '0);              // 8 must still hold its first value
    nop();

    scen = "read then write";
    cyc(0, 1, 6'd9, '0);
    cyc(0, 0, 6'd20, 16'h1234); cont(16'h5678);
    nop();
    cyc(0, 1, 6'd20, '0); cont('0);
    nop();

    scen = "output enable low";
    out_en = 0;
    cyc(0, 1, 6'd8, '0); cont('0);
    nop();
    out_en = 1;
    nop();

    scen = "R10 spare pin toggling";
    cyc(0, 0, 6'd33, 16'h7777); cont(16'h8888);
    cyc(0, 1, 6'd33, '0); cont('0);
    nop(); nop(); nop();

    check(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule